// File: doc/BRIEF.md
# Real-Time-Clock Register Front End

This block sits between a simple 32-bit register bus and the counting logic of a real-time clock. It stores a control/status word, a packed calendar date word, a packed time-of-day word and a bank of scratch words. Software writes and reads them with single-cycle strobes, a byte offset and 32-bit data. Whenever software writes the date or the time word, a sticky "update pending" bit is set in the control word. Reading the control word returns its value and clears both pending bits in the same access. The counting logic outside the block can therefore tell which fields have been reprogrammed since it last looked.

A parameter chooses one of two sparse address layouts. The compact layout has four scratch words. The wide layout spreads the registers out and has eight scratch words. Any offset that is misaligned, beyond the map or has no register assigned reads as zero and cannot be written, and such an access raises a one-cycle error pulse. At reset every register is cleared. When the configured base year lies above 1900, the date and time words are instead loaded from preset input ports, so the clock starts from the current date and time.

Top module: `rtc_regfile`

## Requirements
- R1: A write to the date offset sets control bit 7. A write to the time offset sets control bit 8. Both bits stay set until the control word is read.
- R2: A read of the control word (offset 0x000 in both layouts) returns its current value, with the date bit at 7 and the time bit at 8, and clears both bits. The next read returns them as zero.
- R3: The date and time words read back the full 32-bit value last written. The date word holds the year offset in bits 31:16, the month in 15:8 and the day in 7:0. The time word holds the weekday (0 = Monday) in 31:29, the hour in 20:16, the minute in 13:8 and the second in 5:0.
- R4: With LAYOUT=0 the date word is at offset 0x004 and the time word at 0x008. With LAYOUT=1 they are at 0x010 and 0x014. In each layout, the other layout's date and time offsets are unassigned.
- R5: With LAYOUT=0 there are scratch words 0 to 3 at 0x020 + 4*n. With LAYOUT=1 there are scratch words 0 to 7 at 0x100 + 4*n. Each reads back exactly what was last written to it.
- R6: A read of a misaligned, unassigned or out-of-range offset returns zero. Any access to such an offset makes `err` high for exactly one cycle, in the same cycle that read data becomes valid. Valid accesses leave `err` low.
- R7: A write to a misaligned, unassigned or out-of-range offset changes no register and sets no pending bit.
- R8: Read data is registered and appears in the cycle after the read strobe. `rdata` holds its value when no read is performed. A read strobe that comes in the same cycle as a write strobe is ignored: `rdata` holds and no pending bit is cleared.
- R9: After reset `rdata` is zero, the control word and all scratch words read zero, and the date and time words read `preset_date` and `preset_time` when BASE_YEAR > 1900, otherwise zero.
- R10: A write to the control word has no effect: it neither sets nor clears a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Byte offset of the access |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| err | output | 1 | One-cycle pulse for an access to an invalid offset |
| preset_date | input | DW | Date word loaded at reset when BASE_YEAR > 1900 |
| preset_time | input | DW | Time word loaded at reset when BASE_YEAR > 1900 |

## Verification
Both layouts and a copy whose base year is 1900 share one bus, so a single offset is checked against every map at once. A decoder that ignored the layout would accept a date write at the other layout's offset and set a pending bit there. The bench reads the control word twice after date and time writes. A design that failed to clear on read, or cleared only one bit, returns a stale 0x80 or 0x100 on the second read. Collision cycles (read and write strobes together, or a control write after a date write) would expose a design that clears flags on an ignored read. Misaligned and unassigned writes are followed by read-back of the neighbouring word, which catches decoding that drops the low address bits.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int LAYOUT    = 0,
  parameter int BASE_YEAR = (LAYOUT == 0) ? 2010 : 1970,
  parameter int AW        = 12,
  parameter int DW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err,
  input  logic [DW-1:0] preset_date,
  input  logic [DW-1:0] preset_time
);

  localparam int NSCR     = (LAYOUT == 0) ? 4 : 8;
  localparam int IW       = $clog2(NSCR);
  localparam int OFF_DATE = (LAYOUT == 0) ? 'h004 : 'h010;
  localparam int OFF_TIME = (LAYOUT == 0) ? 'h008 : 'h014;
  localparam int SCR_BASE = (LAYOUT == 0) ? 'h020 : 'h100;
  localparam int SCR_END  = SCR_BASE + 4 * NSCR;
  localparam bit PRELOAD  = BASE_YEAR > 1900;
  localparam int BIT_DATE = 7;

  logic aligned, hit_ctl, hit_date, hit_time, hit_scr, hit, do_rd;
  logic [IW-1:0] scr_idx;
  logic flag_d, flag_t;
  logic [DW-1:0] date_q, time_q, ctl_val, rd_val;
  logic [DW-1:0] scr_rd [NSCR];

  assign aligned  = addr[1:0] == 2'b00;
  assign hit_ctl  = aligned && addr == AW'(0);
  assign hit_date = aligned && addr == AW'(OFF_DATE);
  assign hit_time = aligned && addr == AW'(OFF_TIME);
  assign hit_scr  = aligned && addr >= AW'(SCR_BASE) && addr < AW'(SCR_END);
  assign hit      = hit_ctl | hit_date | hit_time | hit_scr;
  assign scr_idx  = IW'((addr - AW'(SCR_BASE)) >> 2);
  assign do_rd    = rd_en & ~wr_en;
  assign ctl_val  = DW'({flag_t, flag_d}) << BIT_DATE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_d <= 1'b0;
      flag_t <= 1'b0;
    end else begin
      if (wr_en && hit_date)      flag_d <= 1'b1;
      else if (do_rd && hit_ctl)  flag_d <= 1'b0;
      if (wr_en && hit_time)      flag_t <= 1'b1;
      else if (do_rd && hit_ctl)  flag_t <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      date_q <= PRELOAD ? preset_date : '0;
      time_q <= PRELOAD ? preset_time : '0;
    end else begin
      if (wr_en && hit_date) date_q <= wdata;
      if (wr_en && hit_time) time_q <= wdata;
    end
  end

  for (genvar i = 0; i < NSCR; i++) begin : g_scr
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   q <= '0;
      else if (wr_en && hit_scr && scr_idx == IW'(i)) q <= wdata;
    end
    assign scr_rd[i] = q;
  end

  always_comb begin
    rd_val = '0;
    if (hit_ctl)       rd_val = ctl_val;
    else if (hit_date) rd_val = date_q;
    else if (hit_time) rd_val = time_q;
    else if (hit_scr)  rd_val = scr_rd[scr_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (do_rd) rdata <= rd_val;
      err <= (wr_en | rd_en) & ~hit;
    end
  end

  a_r1_date_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_date) |=> flag_d);

  a_r1_time_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_time) |=> flag_t);

  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && hit_ctl) |=> (!flag_d && !flag_t));

  a_r6_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr_en || rd_en));

  a_r7_bad_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> ($stable(date_q) && $stable(time_q) && $stable(flag_d) && $stable(flag_t)));

  a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !do_rd |=> $stable(rdata));

  a_r10_ctl_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ctl) |=> ($stable(flag_d) && $stable(flag_t)));

endmodule

// File: tb/rtc_regfile_test.sv
module rtc_regfile_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata, pdate, ptime;
  logic [31:0] rd_a, rd_b, rd_c;
  logic er_a, er_b, er_c;

  localparam logic [31:0] PD = 32'h000F_0C1F;
  localparam logic [31:0] PT = 32'h8017_3B3A;

  rtc_regfile #(.LAYOUT(0)) uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rd_a), .err(er_a), .preset_date(pdate), .preset_time(ptime));
  rtc_regfile #(.LAYOUT(1)) uut_b (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rd_b), .err(er_b), .preset_date(pdate), .preset_time(ptime));
  rtc_regfile #(.LAYOUT(0), .BASE_YEAR(1900)) uut_c (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rd_c), .err(er_c), .preset_date(pdate), .preset_time(ptime));

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic t_reset;
    chk("R9 rdata after reset", rd_a, 0);
    rd(12'h000); chk("R9 ctl A", rd_a, 0); chk("R9 ctl B", rd_b, 0); chk("R9 ctl C", rd_c, 0);
    rd(12'h004); chk("R9 date A preset", rd_a, PD); chk("R9 date C zero", rd_c, 0);
    chk("R4 B has no 0x004", rd_b, 0); chk("R6 err B", er_b, 1); chk("R6 no err A", er_a, 0);
    rd(12'h008); chk("R9 time A preset", rd_a, PT); chk("R9 time C zero", rd_c, 0);
    rd(12'h010); chk("R9 date B preset", rd_b, PD); chk("R4 A has no 0x010", rd_a, 0); chk("R6 err A", er_a, 1);
    rd(12'h014); chk("R9 time B preset", rd_b, PT);
    rd(12'h020); chk("R9 scratch A zero", rd_a, 0);
    rd(12'h11C); chk("R9 scratch B zero", rd_b, 0);
  endtask

  task automatic t_flags;
    wr(12'h004, 32'h1); rd(12'h000); chk("R1 date flag", rd_a, 32'h80);
    rd(12'h000); chk("R2 cleared", rd_a, 0);
    wr(12'h008, 32'h2); rd(12'h000); chk("R1 time flag", rd_a, 32'h100);
    wr(12'h004, 32'h3); wr(12'h008, 32'h4); rd(12'h000); chk("R2 both flags", rd_a, 32'h180);
    rd(12'h000); chk("R2 both cleared", rd_a, 0);
    wr(12'h014, 32'h5); rd(12'h000); chk("R1 time flag B", rd_b, 32'h100); chk("R4 A untouched by 0x014", rd_a, 0);
    rd(12'h000); chk("R2 cleared B", rd_b, 0);
  endtask

  task automatic t_fields;
    logic [31:0] dv, tv;
    dv = {16'd14, 8'd2, 8'd29};
    tv = {3'd6, 8'd0, 5'd13, 2'd0, 6'd45, 2'd0, 6'd7};
    wr(12'h004, dv); rd(12'h004);
    chk("R3 date word", rd_a, dv); chk("R3 month", 32'(rd_a[15:8]), 2);
    chk("R3 day", 32'(rd_a[7:0]), 29); chk("R3 year", 32'(rd_a[31:16]), 14);
    wr(12'h008, tv); rd(12'h008);
    chk("R3 time word", rd_a, tv); chk("R3 weekday", 32'(rd_a[31:29]), 6);
    chk("R3 hour", 32'(rd_a[20:16]), 13); chk("R3 minute", 32'(rd_a[13:8]), 45);
    chk("R3 second", 32'(rd_a[5:0]), 7);
    rd(12'h000);
  endtask

  task automatic t_ctl_write;
    wr(12'h000, 32'hFFFF_FFFF); rd(12'h000);
    chk("R10 ctl write no set A", rd_a, 0); chk("R10 ctl write no set B", rd_b, 0);
    wr(12'h004, 32'h7); wr(12'h000, 32'h0); rd(12'h000);
    chk("R10 ctl write no clear", rd_a, 32'h80);
  endtask

  task automatic t_scratch;
    for (int i = 0; i < 4; i++) wr(12'(32'h020 + 4 * i), 32'hA500_0000 + i);
    for (int i = 0; i < 8; i++) wr(12'(32'h100 + 4 * i), 32'h5A00_0000 + i);
    for (int i = 0; i < 4; i++) begin
      rd(12'(32'h020 + 4 * i)); chk("R5 scratch A", rd_a, 32'hA500_0000 + i);
    end
    for (int i = 0; i < 8; i++) begin
      rd(12'(32'h100 + 4 * i)); chk("R5 scratch B", rd_b, 32'h5A00_0000 + i);
    end
    rd(12'h110); chk("R5 A has 4 words", rd_a, 0); chk("R6 err A 0x110", er_a, 1);
    chk("R5 B word 4", rd_b, 32'h5A00_0004); chk("R6 no err B", er_b, 0);
    rd(12'h020); chk("R4 B no scratch at 0x020", rd_b, 0); chk("R6 err B 0x020", er_b, 1);
  endtask

  task automatic t_invalid;
    wr(12'h004, 32'h1111_2222); rd(12'h000);
    wr(12'h006, 32'hDEAD_0000); chk("R6 misaligned write err", er_a, 1);
    rd(12'h004); chk("R7 misaligned write inert", rd_a, 32'h1111_2222); chk("R6 err low", er_a, 0);
    rd(12'h000); chk("R7 no flag from bad write", rd_a, 0);
    wr(12'h022, 32'hBEEF_BEEF); rd(12'h020); chk("R7 scratch untouched", rd_a, 32'hA500_0000);
    wr(12'h03C, 32'h1234_5678); chk("R6 unassigned write err", er_a, 1);
    rd(12'h03C); chk("R6 unassigned read zero", rd_a, 0); chk("R6 unassigned read err", er_a, 1);
    @(negedge clk); chk("R6 err one cycle", er_a, 0);
    rd(12'h1F4); chk("R6 out of range B", rd_b, 0); chk("R6 err B range", er_b, 1);
    rd(12'h007); chk("R6 misaligned read zero", rd_a, 0);
  endtask

  task automatic t_rdwr;
    rd(12'h024); chk("R8 read scratch", rd_a, 32'hA500_0001);
    wr(12'h004, 32'h9);
    @(negedge clk); wr_en = 1; rd_en = 1; addr = 12'h000; wdata = 0;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R8 rdata holds on collision", rd_a, 32'hA500_0001);
    rd(12'h000); chk("R8 collided read did not clear", rd_a, 32'h80);
    @(negedge clk); rd_en = 1; addr = 12'h028;
    #1 chk("R8 not yet updated", rd_a, 32'h80);
    @(negedge clk); rd_en = 0;
    chk("R8 one cycle latency", rd_a, 32'hA500_0002);
    @(negedge clk); chk("R8 holds without read", rd_a, 32'hA500_0002);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; pdate = PD; ptime = PT;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_flags();
    t_fields();
    t_ctl_write();
    t_scratch();
    t_invalid();
    t_rdwr();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule